// File: doc/BRIEF.md
# Indirect Jump Target Resolver

This block turns the 32-bit address of an indirect jump into a code offset. The address is produced elsewhere, as a register plus an immediate. The block uses a jump table held in an internal RAM, which is filled through a write port. Table entry `i` is reached through the address `2*(i+1)`. The offset read from the table is then checked against a bitmap that marks which code bytes begin a basic block.

Each request ends in one of three outcomes:
- a valid jump, carrying its target offset;
- a halt, for the reserved address `0xFFFF0000`;
- a panic, for any malformed or out-of-bounds jump.

A second, purely combinational port checks a direct jump target against the same bitmap.

Requests enter on a valid/ready input stream and results leave on a valid/ready output stream. The two pipeline registers advance together whenever the output register is empty or is being taken. `req_ready` is therefore low exactly while a response is held with `rsp_ready` low. A held response keeps every output field stable until it is taken. A new request can be accepted in the same cycle in which the previous response leaves. The table and the bitmap are meant to be written while no request is in flight.

Top module: `dyn_jump_resolver`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. With `rsp_ready` held high, its response is first visible after the second rising edge counted from the accepting edge. `rsp_valid` is low after the accepting edge alone.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response fields stay unchanged. The response leaves on the first edge with `rsp_ready` high.
- R3: Take a nonzero even address A other than `0xFFFF0000`, and let index = A/2 − 1. If the index is below `tbl_len`, the table entry E at that index is below `CODE_BYTES`, and bitmap bit E is set, the response has `rsp_ok` = 1 and `rsp_target` = E.
- R4: Address `0xFFFF0000` gives `rsp_halt`. This check comes before the alignment, range and table checks, so it holds even when `tbl_len` is 0.
- R5: An odd address gives `rsp_panic`.
- R6: Address 0 (index −1) gives `rsp_panic`.
- R7: An index equal to or above `tbl_len` gives `rsp_panic`. The index `tbl_len`−1 is still accepted.
- R8: A table entry whose bitmap bit is clear, or which is not below `CODE_BYTES`, gives `rsp_panic`.
- R9: With each response exactly one of `rsp_ok`, `rsp_halt` and `rsp_panic` is high. `rsp_target` is 0 unless `rsp_ok` is high. All three flags are low while `rsp_valid` is low.
- R10: `sj_is_start` equals bitmap bit `sj_target` whenever `sj_target` < `CODE_BYTES`, and is 0 otherwise. It responds within the same cycle.
- R11: A write with `bmp_wr_en` high replaces bitmap word w. Bit i of `bmp_wr_data` becomes the flag of offset w*BMP_W+i. A write with `tbl_wr_en` high stores `tbl_wr_data` at entry `tbl_wr_idx`. Both take effect from the next cycle.
- R12: After reset, `rsp_valid` is 0, `req_ready` is 1, and the whole bitmap is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Computed indirect jump address |
| tbl_len | input | IDX_W+1 | Number of loaded table entries |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Table entry written |
| tbl_wr_data | input | OFS_W | Code offset stored |
| bmp_wr_en | input | 1 | Bitmap word write strobe |
| bmp_wr_idx | input | WIDX_W | Bitmap word written |
| bmp_wr_data | input | BMP_W | Block-start flags for that word |
| sj_target | input | OFS_W | Direct jump target to test |
| sj_is_start | output | 1 | Direct target begins a basic block |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ok | output | 1 | Jump is valid |
| rsp_halt | output | 1 | Halt outcome |
| rsp_panic | output | 1 | Panic outcome |
| rsp_target | output | OFS_W | Resolved code offset (0 unless ok) |

## Verification
The decode stage and the table RAM read share the accepting edge, and the outcome register loads one edge later. A response is therefore due after the second rising edge following acceptance, and the bench samples it on the falling edge that follows. On the falling edge between those two rising edges, the bench confirms that `rsp_valid` is still low. The static block-start port is combinational, so it is sampled on the falling edge right after its input changes. Table and bitmap writes are checked on the falling edge after their write edge. In the back-pressure scenario, the bench holds the response for several cycles and compares it at every falling edge until the edge that takes it.

// File: rtl/djt_pkg.sv
package djt_pkg;
  localparam logic [31:0] HALT_ADDR = 32'hFFFF_0000;

  typedef enum logic [1:0] {
    RES_JUMP  = 2'd0,
    RES_HALT  = 2'd1,
    RES_PANIC = 2'd2
  } res_kind_e;
endpackage

// File: rtl/djt_addr_check.sv
// Classifies a raw jump address before the table is read.
// Priority: halt address, then alignment, then zero, then range.
module djt_addr_check
  import djt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W:0]    tbl_len,
  output res_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-2:0] half;
  logic [ADDR_W-2:0] idx_w;

  always_comb begin
    half  = addr[ADDR_W-1:1];
    idx_w = half - 1'b1;
    kind  = RES_JUMP;
    if (addr == ADDR_W'(HALT_ADDR)) begin
      kind = RES_HALT;
    end else if (addr[0]) begin
      kind = RES_PANIC;
    end else if (half == '0) begin
      kind = RES_PANIC;
    end else if (idx_w >= (ADDR_W-1)'(tbl_len)) begin
      kind = RES_PANIC;
    end
  end

  assign idx = idx_w[IDX_W-1:0];

  // R5: misaligned addresses never pass decode
  always_comb begin
    if (addr[0] === 1'b1 && addr !== ADDR_W'(HALT_ADDR))
      a_r5_odd_panics : assert (kind == RES_PANIC);
  end
endmodule

// File: rtl/djt_jump_table.sv
// Jump table storage with a registered read port.
module djt_jump_table #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [OFS_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [OFS_W-1:0] rdata
);
  logic [OFS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/djt_block_map.sv
// Basic-block-start bitmap, written by word, with NPORT lookup ports.
module djt_block_map #(
  parameter int CODE_BYTES = 1024,
  parameter int BMP_W      = 32,
  parameter int OFS_W      = 16,
  parameter int NPORT      = 2,
  localparam int WORDS     = CODE_BYTES / BMP_W,
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int BIT_W     = $clog2(BMP_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [WIDX_W-1:0]           widx,
  input  logic [BMP_W-1:0]            wdata,
  input  logic [NPORT-1:0][OFS_W-1:0] q_ofs,
  output logic [NPORT-1:0]            q_hit
);
  logic [BMP_W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) words[w] <= '0;
    end else if (we) begin
      words[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic             in_code;
    logic [BMP_W-1:0] word;
    assign in_code  = {1'b0, q_ofs[p]} < (OFS_W+1)'(CODE_BYTES);
    assign word     = words[q_ofs[p][BIT_W +: WIDX_W]];
    assign q_hit[p] = in_code && word[q_ofs[p][BIT_W-1:0]];
  end
endmodule

// File: rtl/dyn_jump_resolver.sv
module dyn_jump_resolver
  import djt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 16,
  parameter int TBL_DEPTH  = 64,
  parameter int CODE_BYTES = 1024,
  parameter int BMP_W      = 32,
  localparam int IDX_W     = $clog2(TBL_DEPTH),
  localparam int WIDX_W    = $clog2(CODE_BYTES / BMP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W:0]    tbl_len,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [OFS_W-1:0]  tbl_wr_data,
  input  logic              bmp_wr_en,
  input  logic [WIDX_W-1:0] bmp_wr_idx,
  input  logic [BMP_W-1:0]  bmp_wr_data,
  input  logic [OFS_W-1:0]  sj_target,
  output logic              sj_is_start,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic              rsp_halt,
  output logic              rsp_panic,
  output logic [OFS_W-1:0]  rsp_target
);
  // pipeline control
  logic advance, accept;
  assign advance   = !rsp_valid || rsp_ready;
  assign req_ready = advance;
  assign accept    = req_valid && advance;

  // stage 1: address decode and table read
  res_kind_e        dec_kind;
  logic [IDX_W-1:0] dec_idx;

  djt_addr_check #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_check (
    .addr    (req_addr),
    .tbl_len (tbl_len),
    .kind    (dec_kind),
    .idx     (dec_idx)
  );

  logic [OFS_W-1:0] ram_q;

  djt_jump_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_wr_en),
    .widx  (tbl_wr_idx),
    .wdata (tbl_wr_data),
    .re    (accept),
    .ridx  (dec_idx),
    .rdata (ram_q)
  );

  logic      s1_v;
  res_kind_e s1_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_kind <= RES_PANIC;
    end else if (advance) begin
      s1_v    <= req_valid;
      s1_kind <= dec_kind;
    end
  end

  // block-start lookups: port 0 for the table entry, port 1 for direct targets
  logic [1:0][OFS_W-1:0] look_ofs;
  logic [1:0]            look_hit;
  assign look_ofs = {sj_target, ram_q};

  djt_block_map #(.CODE_BYTES(CODE_BYTES), .BMP_W(BMP_W), .OFS_W(OFS_W), .NPORT(2)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bmp_wr_en),
    .widx  (bmp_wr_idx),
    .wdata (bmp_wr_data),
    .q_ofs (look_ofs),
    .q_hit (look_hit)
  );

  assign sj_is_start = look_hit[1];

  // stage 2: final outcome
  res_kind_e fin_kind;
  always_comb begin
    fin_kind = s1_kind;
    if (s1_kind == RES_JUMP && !look_hit[0]) fin_kind = RES_PANIC;
  end

  logic      rsp_v;
  res_kind_e rsp_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v      <= 1'b0;
      rsp_kind   <= RES_PANIC;
      rsp_target <= '0;
    end else if (advance) begin
      rsp_v      <= s1_v;
      rsp_kind   <= fin_kind;
      rsp_target <= (s1_v && fin_kind == RES_JUMP) ? ram_q : '0;
    end
  end

  assign rsp_valid = rsp_v;
  assign rsp_ok    = rsp_v && rsp_kind == RES_JUMP;
  assign rsp_halt  = rsp_v && rsp_kind == RES_HALT;
  assign rsp_panic = rsp_v && rsp_kind == RES_PANIC;

  // assertions
  a_r9_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_halt, rsp_panic}) == 1);

  a_r2_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_target)
      && $stable({rsp_ok, rsp_halt, rsp_panic})));

  a_r2_no_accept_stalled : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r1_latency : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready, 2));

  a_r8_target_in_code : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> ({1'b0, rsp_target} < (OFS_W+1)'(CODE_BYTES)));
endmodule

// File: tb/dyn_jump_resolver_tb_top.sv
module dyn_jump_resolver_tb_top;
  localparam int ADDR_W = 32, OFS_W = 16, IDX_W = 6, WIDX_W = 5, BMP_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, req_valid, req_ready, tbl_wr_en, bmp_wr_en;
  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W:0]    tbl_len;
  logic [IDX_W-1:0]  tbl_wr_idx;
  logic [OFS_W-1:0]  tbl_wr_data, sj_target, rsp_target;
  logic [WIDX_W-1:0] bmp_wr_idx;
  logic [BMP_W-1:0]  bmp_wr_data;
  logic              sj_is_start, rsp_valid, rsp_ready, rsp_ok, rsp_halt, rsp_panic;

  dyn_jump_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .tbl_len(tbl_len), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data), .bmp_wr_en(bmp_wr_en),
    .bmp_wr_idx(bmp_wr_idx), .bmp_wr_data(bmp_wr_data), .sj_target(sj_target),
    .sj_is_start(sj_is_start), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ok(rsp_ok), .rsp_halt(rsp_halt), .rsp_panic(rsp_panic),
    .rsp_target(rsp_target)
  );

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  localparam int K_OK = 1, K_HALT = 2, K_PANIC = 4;

  task automatic chk(input bit good, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic wr_tbl(input int idx, input int ofs);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = IDX_W'(idx); tbl_wr_data = OFS_W'(ofs);
    @(posedge clk); @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic wr_bmp(input int w, input logic [31:0] bits);
    @(negedge clk);
    bmp_wr_en = 1; bmp_wr_idx = WIDX_W'(w); bmp_wr_data = bits;
    @(posedge clk); @(negedge clk);
    bmp_wr_en = 0;
  endtask

  // one request with rsp_ready high; checks the R1 timing and the outcome
  task automatic do_req(input logic [31:0] addr, input int kind,
                        input int tgt, input string tag);
    logic [2:0] flags;
    @(negedge clk);
    req_valid = 1; req_addr = addr;
    chk(req_ready == 1'b1, {tag, "/R1 ready"}, 32'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1'b0, {tag, "/R1 early"}, 32'(rsp_valid), 0);
    @(posedge clk); @(negedge clk);
    flags = {rsp_panic, rsp_halt, rsp_ok};
    chk(rsp_valid == 1'b1, {tag, "/R1 due"}, 32'(rsp_valid), 1);
    chk(flags == 3'(kind), {tag, "/R9 flags"}, 32'(flags), 32'(kind));
    chk(rsp_target == OFS_W'(tgt), {tag, " target"}, 32'(rsp_target), 32'(tgt));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R12 reset handshake",
        {30'd0, rsp_valid, req_ready}, 1);
    chk({rsp_ok, rsp_halt, rsp_panic} == 0, "R9 idle flags",
        32'({rsp_ok, rsp_halt, rsp_panic}), 0);
    sj_target = 16'd4;
    #1 chk(sj_is_start == 0, "R12 bitmap clear", 32'(sj_is_start), 0);
  endtask

  task automatic t_load();
    wr_tbl(0, 4);   wr_tbl(1, 10);  wr_tbl(2, 2000); wr_tbl(3, 33);
    wr_tbl(4, 100); wr_tbl(5, 200); wr_tbl(6, 5);    wr_tbl(7, 1023);
    wr_tbl(8, 4);
    wr_bmp(0, (32'd1 << 4) | (32'd1 << 10) | (32'd1 << 20));
    wr_bmp(1, 32'd1 << 1);
    wr_bmp(3, 32'd1 << 4);
    wr_bmp(6, 32'd1 << 8);
    wr_bmp(31, 32'd1 << 31);
    tbl_len = 7'd8;
  endtask

  task automatic t_static();
    @(negedge clk); sj_target = 16'd33;   #1 chk(sj_is_start == 1, "R10 R11 ofs 33", 32'(sj_is_start), 1);
    @(negedge clk); sj_target = 16'd34;   #1 chk(sj_is_start == 0, "R10 ofs 34", 32'(sj_is_start), 0);
    @(negedge clk); sj_target = 16'd1023; #1 chk(sj_is_start == 1, "R10 R11 ofs 1023", 32'(sj_is_start), 1);
    @(negedge clk); sj_target = 16'd1024; #1 chk(sj_is_start == 0, "R10 beyond code", 32'(sj_is_start), 0);
    @(negedge clk); sj_target = 16'd200;  #1 chk(sj_is_start == 1, "R10 ofs 200", 32'(sj_is_start), 1);
  endtask

  task automatic t_valid_jumps();
    do_req(32'd2,  K_OK, 4,    "R3 idx0");
    do_req(32'd8,  K_OK, 33,   "R3 idx3");
    do_req(32'd12, K_OK, 200,  "R3 idx5");
    do_req(32'd16, K_OK, 1023, "R7 last idx");
  endtask

  task automatic t_panics();
    do_req(32'd3,          K_PANIC, 0, "R5 odd");
    do_req(32'hFFFF_0001,  K_PANIC, 0, "R5 odd near halt");
    do_req(32'd0,          K_PANIC, 0, "R6 zero");
    do_req(32'd18,         K_PANIC, 0, "R7 idx=len");
    do_req(32'hFFFF_0002,  K_PANIC, 0, "R7 huge idx");
    do_req(32'd14,         K_PANIC, 0, "R8 not block start");
    do_req(32'd6,          K_PANIC, 0, "R8 entry beyond code");
  endtask

  task automatic t_halt();
    do_req(32'hFFFF_0000, K_HALT, 0, "R4 halt");
    tbl_len = 7'd0;
    do_req(32'hFFFF_0000, K_HALT, 0, "R4 halt empty table");
    do_req(32'd2, K_PANIC, 0, "R7 empty table");
    tbl_len = 7'd8;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'd10;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_ok && rsp_target == 16'd100, "R2 held",
          32'(rsp_target), 100);
      chk(req_ready == 0, "R2 ready low", 32'(req_ready), 0);
      @(posedge clk);
    end
    @(negedge clk);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R2 taken", 32'(rsp_valid), 0);
  endtask

  task automatic t_rewrite();
    wr_bmp(0, 32'd1 << 10);
    @(negedge clk); sj_target = 16'd4; #1
    chk(sj_is_start == 0, "R11 rewritten word", 32'(sj_is_start), 0);
    do_req(32'd2, K_PANIC, 0, "R11 R8 cleared start");
    wr_tbl(0, 10);
    do_req(32'd2, K_OK, 10, "R11 table rewrite");
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; tbl_len = '0; tbl_wr_en = 0;
    tbl_wr_idx = '0; tbl_wr_data = '0; bmp_wr_en = 0; bmp_wr_idx = '0;
    bmp_wr_data = '0; sj_target = '0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_load();
    t_static();
    t_valid_jumps();
    t_panics();
    t_halt();
    t_backpressure();
    t_rewrite();
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule